// File: doc/BRIEF.md
# Successive-Approximation Converter Serial Readout Controller

This block runs conversions on one or more 18-bit successive-approximation converters and collects their results over a three-wire serial link. A start request makes the controller set the data-in/mode line and then raise the conversion-start strobe. The level of the data-in line at that rising edge tells the converter which link mode to use. When conversion is complete, the controller drives a divided serial clock, samples the converter's serial output on each rising clock edge and assembles the results most significant bit first.

There are two link modes. In chip-select mode the data-in line is high at the strobe edge and a single 18-bit result is read. In chain mode the data-in line is low. Several converters pass their results through one another, and the controller reads them as one stream of N_DEV × 18 bits, holding its data-in line low so that zeros follow the data. The end of conversion is found in one of two ways. The controller can wait a programmed number of system clocks. It can instead wait for the busy indicator, which is a high level on the data output line after the strobe has been dropped. In that case one extra serial clock cycle consumes the indicator before the data bits. Each result is delivered as a signed two's-complement word with a one-cycle valid strobe and its position in the stream.

Top module: `sar_readout_ctrl`

## Requirements
- R1: After reset, cnv_o, sclk_o, res_vld_o and busy_o are low and sdi_o is high.
- R2: A start_i pulse while busy_o is low begins a run. chain_i, busy_en_i, half_div_i and conv_cyc_i are captured in that cycle, and later changes have no effect on the run. sdi_o is 1 for chip-select mode (chain_i=0) and 0 for chain mode (chain_i=1) at the cnv_o rising edge, and it keeps that level until the run ends.
- R3: With busy_en_i=0, cnv_o stays high for exactly max(conv_cyc_i,1) clocks, and sclk_o first rises only after cnv_o has fallen.
- R4: With busy_en_i=1, cnv_o is high for one clock and then low. No sclk_o rising edge occurs until sdo_i has been seen high. The first rising-edge sample after that (the indicator) is discarded, so the run issues 18·words+1 rising edges.
- R5: While busy_o is high, sclk_o toggles with a half period of max(half_div_i,1) clocks. It is low whenever busy_o is low, and it is never high while cnv_o is high.
- R6: sdo_i is sampled at each sclk_o rising edge. Each result is 18 bits, most significant bit first, and res_o is its signed two's-complement value (18'h20000 reads as -131072).
- R7: Chip-select mode yields one result with res_idx_o=0. Chain mode yields N_DEV results in the order received, with res_idx_o counting from 0, and exactly 18·N_DEV data clocks.
- R8: Each result is presented with a res_vld_o pulse one clock wide.
- R9: A run ends with sclk_o low and busy_o low, after which a new start is accepted. A start_i pulse while busy_o is high is ignored: cnv_o does not rise again and no extra result appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion-and-readout run |
| chain_i | input | 1 | 1 selects chain mode, 0 chip-select mode |
| busy_en_i | input | 1 | 1 waits for the busy indicator, 0 waits conv_cyc_i clocks |
| half_div_i | input | DIV_W | Serial clock half period in system clocks (0 acts as 1) |
| conv_cyc_i | input | CNV_W | Conversion-start high time in system clocks (0 acts as 1) |
| sdo_i | input | 1 | Serial data from the converter (last in chain) |
| cnv_o | output | 1 | Conversion-start strobe |
| sclk_o | output | 1 | Serial clock to the converter |
| sdi_o | output | 1 | Data-in/mode line to the converter |
| res_o | output | RES_W | Signed result word |
| res_idx_o | output | IDX_W | Position of the result in the stream |
| res_vld_o | output | 1 | One-cycle result valid strobe |
| busy_o | output | 1 | High from accepted start until the run ends |

## Verification
A wrong sequencer state shows at the ports within a cycle or two. The strobe is held for the wrong time, the mode level is wrong at the strobe edge, or serial clocks start while the converter is still busy. A slipped bit or word counter changes the number of serial clock edges in the run and shifts the data of every later word by one bit. A converter model that takes its mode from the data-in line turns such a slip into a wrong value at the next valid strobe. A divider fault changes the measured half period on the first toggle.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

    localparam int unsigned DEF_RES_W = 18;
    localparam int unsigned DEF_N_DEV = 2;
    localparam int unsigned DEF_DIV_W = 8;
    localparam int unsigned DEF_CNV_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CONV,
        ST_WAITB,
        ST_SHIFT,
        ST_TAIL
    } seq_state_e;

    typedef enum logic {
        LINK_CS    = 1'b0,
        LINK_CHAIN = 1'b1
    } link_mode_e;

    typedef struct packed {
        link_mode_e mode;
        logic       use_busy;
    } run_cfg_t;

    // Level of the data-in line that selects the given link mode
    function automatic logic mode_level(link_mode_e m);
        return (m == LINK_CS);
    endfunction

    function automatic link_mode_e mode_from_pin(logic chain);
        return chain ? LINK_CHAIN : LINK_CS;
    endfunction

endpackage

// File: rtl/sar_sclk_gen.sv
module sar_sclk_gen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             sclk_o,
    output logic             rise_o,
    output logic             fall_o
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;
    logic             tick;

    always_comb begin
        lim    = (half_i == '0) ? '0 : half_i - 1'b1;
        tick   = run_i && (cnt_q == lim);
        rise_o = tick && !sclk_o;
        fall_o = tick && sclk_o;
    end

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q  <= '0;
            sclk_o <= 1'b0;
        end else if (tick) begin
            cnt_q  <= '0;
            sclk_o <= !sclk_o;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sar_deser.sv
module sar_deser #(
    parameter int unsigned RES_W = 18,
    parameter int unsigned IDX_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             skip_i,
    input  logic [IDX_W-1:0] last_idx_i,
    input  logic             sample_i,
    input  logic             sdo_i,
    output logic [RES_W-1:0] word_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             vld_o,
    output logic             last_o
);

    localparam int unsigned CNT_W = $clog2(RES_W + 1);

    logic [RES_W-1:0] sh_q;
    logic [RES_W-1:0] sh_n;
    logic [CNT_W-1:0] bit_q;
    logic [IDX_W-1:0] widx_q;
    logic             skip_q;
    logic             take;
    logic             word_end;

    always_comb begin
        take     = sample_i && !skip_q;
        sh_n     = {sh_q[RES_W-2:0], sdo_i};
        word_end = take && (bit_q == CNT_W'(RES_W - 1));
        last_o   = word_end && (widx_q == last_idx_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            bit_q  <= '0;
            widx_q <= '0;
            skip_q <= 1'b0;
            word_o <= '0;
            idx_o  <= '0;
            vld_o  <= 1'b0;
        end else begin
            vld_o <= 1'b0;
            if (clr_i) begin
                sh_q   <= '0;
                bit_q  <= '0;
                widx_q <= '0;
                skip_q <= skip_i;
            end else if (sample_i) begin
                if (skip_q) begin
                    skip_q <= 1'b0;
                end else begin
                    sh_q <= sh_n;
                    if (word_end) begin
                        bit_q  <= '0;
                        widx_q <= widx_q + 1'b1;
                        word_o <= sh_n;
                        idx_o  <= widx_q;
                        vld_o  <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_rd_pkg::*;
#(
    parameter int unsigned DIV_W = 8,
    parameter int unsigned CNV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             chain_i,
    input  logic             busy_en_i,
    input  logic [DIV_W-1:0] half_i,
    input  logic [CNV_W-1:0] conv_i,
    input  logic             busy_seen_i,
    input  logic             last_i,
    input  logic             fall_i,
    output seq_state_e       state_o,
    output run_cfg_t         cfg_o,
    output logic [DIV_W-1:0] half_q_o,
    output logic             launch_o
);

    logic [CNV_W-1:0] conv_q;
    logic [CNV_W-1:0] tcnt_q;
    logic [CNV_W-1:0] conv_lim;
    seq_state_e       nxt;

    always_comb begin
        conv_lim = (conv_q == '0) ? '0 : conv_q - 1'b1;
        launch_o = (state_o == ST_IDLE) && start_i;
        nxt      = state_o;
        unique case (state_o)
            ST_IDLE:  if (start_i) nxt = ST_SETUP;
            ST_SETUP: nxt = ST_CONV;
            ST_CONV: begin
                if (cfg_o.use_busy)          nxt = ST_WAITB;
                else if (tcnt_q == conv_lim) nxt = ST_SHIFT;
            end
            ST_WAITB: if (busy_seen_i) nxt = ST_SHIFT;
            ST_SHIFT: if (last_i)      nxt = ST_TAIL;
            ST_TAIL:  if (fall_i)      nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_o  <= ST_IDLE;
            cfg_o    <= '{mode: LINK_CS, use_busy: 1'b0};
            half_q_o <= '0;
            conv_q   <= '0;
            tcnt_q   <= '0;
        end else begin
            state_o <= nxt;
            if (launch_o) begin
                cfg_o.mode     <= mode_from_pin(chain_i);
                cfg_o.use_busy <= busy_en_i;
                half_q_o       <= half_i;
                conv_q         <= conv_i;
            end
            tcnt_q <= (state_o == ST_CONV) ? tcnt_q + 1'b1 : '0;
        end
    end

endmodule

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl
    import sar_rd_pkg::*;
#(
    parameter  int unsigned RES_W = DEF_RES_W,
    parameter  int unsigned N_DEV = DEF_N_DEV,
    parameter  int unsigned DIV_W = DEF_DIV_W,
    parameter  int unsigned CNV_W = DEF_CNV_W,
    localparam int unsigned IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic                    chain_i,
    input  logic                    busy_en_i,
    input  logic [DIV_W-1:0]        half_div_i,
    input  logic [CNV_W-1:0]        conv_cyc_i,
    input  logic                    sdo_i,
    output logic                    cnv_o,
    output logic                    sclk_o,
    output logic                    sdi_o,
    output logic signed [RES_W-1:0] res_o,
    output logic [IDX_W-1:0]        res_idx_o,
    output logic                    res_vld_o,
    output logic                    busy_o
);

    seq_state_e       state;
    run_cfg_t         cfg;
    logic [DIV_W-1:0] half_q;
    logic             launch;
    logic             rise;
    logic             fall;
    logic             last;
    logic             sclk_run;
    logic [1:0]       bsync_q;
    logic [IDX_W-1:0] last_idx;
    logic [RES_W-1:0] word;

    // Busy indicator synchronizer, flushed outside the wait state so a
    // stale line level from an earlier run cannot end the wait early.
    always_ff @(posedge clk) begin
        if (rst || state != ST_WAITB) bsync_q <= '0;
        else                          bsync_q <= {bsync_q[0], sdo_i};
    end

    always_comb begin
        sclk_run = (state == ST_SHIFT) || (state == ST_TAIL);
        last_idx = (cfg.mode == LINK_CHAIN) ? IDX_W'(N_DEV - 1) : '0;
        cnv_o    = (state == ST_CONV);
        sdi_o    = (state == ST_IDLE) ? 1'b1 : mode_level(cfg.mode);
        busy_o   = (state != ST_IDLE);
        res_o    = signed'(word);
    end

    sar_seq #(
        .DIV_W (DIV_W),
        .CNV_W (CNV_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .chain_i     (chain_i),
        .busy_en_i   (busy_en_i),
        .half_i      (half_div_i),
        .conv_i      (conv_cyc_i),
        .busy_seen_i (bsync_q[1]),
        .last_i      (last),
        .fall_i      (fall),
        .state_o     (state),
        .cfg_o       (cfg),
        .half_q_o    (half_q),
        .launch_o    (launch)
    );

    sar_sclk_gen #(
        .DIV_W (DIV_W)
    ) u_sclk (
        .clk    (clk),
        .rst    (rst),
        .run_i  (sclk_run),
        .half_i (half_q),
        .sclk_o (sclk_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    sar_deser #(
        .RES_W (RES_W),
        .IDX_W (IDX_W)
    ) u_deser (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (launch),
        .skip_i     (busy_en_i),
        .last_idx_i (last_idx),
        .sample_i   (rise),
        .sdo_i      (sdo_i),
        .word_o     (word),
        .idx_o      (res_idx_o),
        .vld_o      (res_vld_o),
        .last_o     (last)
    );

endmodule

// File: rtl/sar_rd_chk.sv
module sar_rd_chk (
    input logic clk,
    input logic rst,
    input logic cnv,
    input logic sclk,
    input logic sdi,
    input logic vld,
    input logic busy
);

    // R5
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);

    // R5
    cnv_sclk_excl_chk: assert property (@(posedge clk) disable iff (rst)
        cnv |-> !sclk);

    // R2
    sdi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnv && $past(cnv)) |-> $stable(sdi));

    // R8
    vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        vld |=> !vld);

    // R2
    cnv_after_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cnv) |-> $past(busy));

    // R9
    run_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (!sclk && !cnv));

endmodule

bind sar_readout_ctrl sar_rd_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .cnv  (cnv_o),
    .sclk (sclk_o),
    .sdi  (sdi_o),
    .vld  (res_vld_o),
    .busy (busy_o)
);

// File: tb/test_sar_readout_ctrl.sv
module test_sar_readout_ctrl;

    localparam int RW    = 18;
    localparam int ND    = 2;
    localparam int DW    = 8;
    localparam int CW    = 16;
    localparam int SW    = ND * RW + 1;
    localparam int ADC_T = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic                 start = 1'b0, chain = 1'b0, busy_en = 1'b0;
    logic [DW-1:0]        half = '0;
    logic [CW-1:0]        conv = '0;
    logic                 sdo = 1'b0;
    logic                 cnv, sclk, sdi, vld, busy;
    logic signed [RW-1:0] res;
    logic                 idx;

    sar_readout_ctrl i_sar_readout_ctrl (
        .clk (clk), .rst (rst), .start_i (start), .chain_i (chain),
        .busy_en_i (busy_en), .half_div_i (half), .conv_cyc_i (conv),
        .sdo_i (sdo), .cnv_o (cnv), .sclk_o (sclk), .sdi_o (sdi),
        .res_o (res), .res_idx_o (idx), .res_vld_o (vld), .busy_o (busy)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    typedef struct { int i; logic [RW-1:0] w; } exp_t;
    exp_t sb_q[$];

    // converter model and port monitor
    logic [RW-1:0] mdl_w0, mdl_w1;
    bit            mdl_busy;
    logic [SW-1:0] strm;
    bit            converting = 0;
    int            busy_cnt = 0;
    logic          sdi_at_rise = 1'b0;
    int cnv_rises = 0, cnv_hi = 0, sclk_rises = 0, ph_cnt = 0, ph_err = 0;
    int early_clk = 0, overlap = 0, exp_half = 1;
    bit low_from_fall = 0;
    logic prev_cnv = 0, prev_sclk = 0, prev_vld = 0;
    logic signed [RW-1:0] last_res = '0;

    always @(negedge clk) begin
        if (!rst) begin
            logic [SW-2:0] pay;
            exp_t e;
            if (converting && mdl_busy && !cnv && busy_cnt > 0) begin
                busy_cnt--;
                if (busy_cnt == 0) begin converting = 0; sdo = strm[SW-1]; end
            end
            if (cnv && !prev_cnv) begin
                cnv_rises++;
                sdi_at_rise   = sdi;
                pay           = sdi ? {mdl_w0, {RW{1'b0}}} : {mdl_w0, mdl_w1};
                strm          = mdl_busy ? {1'b1, pay} : {pay, 1'b0};
                sdo           = 1'b0;
                converting    = 1;
                low_from_fall = 0;
            end
            if (cnv) cnv_hi++;
            if (!cnv && prev_cnv) begin
                if (mdl_busy) busy_cnt = ADC_T;
                else begin converting = 0; sdo = strm[SW-1]; end
            end
            if (sclk != prev_sclk) begin
                if ((prev_sclk || low_from_fall) && ph_cnt != exp_half) ph_err++;
                ph_cnt = 1;
                low_from_fall = !sclk;
            end else begin
                ph_cnt++;
            end
            if (sclk && !prev_sclk) begin
                sclk_rises++;
                if (converting) early_clk++;
            end
            if (!sclk && prev_sclk) begin
                strm = strm << 1;
                sdo  = strm[SW-1];
            end
            if (cnv && sclk) overlap++;
            if (vld) begin
                last_res = res;
                if (prev_vld) check(0, "R8", "valid wider than one cycle", 2, 1);
                if (sb_q.size() == 0) check(0, "R7", "unexpected result", res, 0);
                else begin
                    e = sb_q.pop_front();
                    check(res === signed'(e.w), "R6", "result word", res, signed'(e.w));
                    check(int'(idx) == e.i, "R7", "result index", idx, e.i);
                end
            end
            prev_cnv  = cnv;
            prev_sclk = sclk;
            prev_vld  = vld;
        end
    end

    task automatic run(input bit ch, input bit bz, input int hd, input int cv,
                       input logic [RW-1:0] w0, input logic [RW-1:0] w1, input bit poke);
        int nw = ch ? ND : 1;
        int ec = (cv == 0) ? 1 : cv;
        mdl_w0   = w0;
        mdl_w1   = w1;
        mdl_busy = bz;
        exp_half = (hd == 0) ? 1 : hd;
        sb_q.push_back('{0, w0});
        if (ch) sb_q.push_back('{1, w1});
        cnv_rises = 0; cnv_hi = 0; sclk_rises = 0; ph_err = 0; early_clk = 0;
        @(negedge clk);
        chain = ch; busy_en = bz; half = DW'(hd); conv = CW'(cv); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: inputs altered after the start must not affect this run
        chain = !ch; busy_en = !bz; half = DW'(hd + 3); conv = CW'(cv + 9);
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1;                      // R9: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        check(sdi_at_rise == !ch, "R2", "mode level at strobe edge", sdi_at_rise, !ch);
        if (bz) check(cnv_hi == 1, "R4", "strobe high time", cnv_hi, 1);
        else    check(cnv_hi == ec, "R3", "strobe high time", cnv_hi, ec);
        check(cnv_rises == 1, "R9", "strobes per run", cnv_rises, 1);
        check(sclk_rises == nw * RW + int'(bz), "R7", "serial clock edges",
              sclk_rises, nw * RW + int'(bz));
        check(ph_err == 0, "R5", "half period mismatches", ph_err, 0);
        check(early_clk == 0, "R4", "clocks during conversion", early_clk, 0);
        check(sb_q.size() == 0, "R7", "missing results", sb_q.size(), 0);
        check(!busy && !sclk, "R9", "idle after run", {busy, sclk}, 0);
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R9 watchdog expired: actual %0d expected %0d", 0, 1);
            finish_up();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!cnv && !sclk && sdi && !vld && !busy, "R1", "reset outputs",
              {cnv, sclk, sdi, vld, busy}, 5'b00100);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && !sclk, "R1", "idle after reset", {busy, sclk}, 0);

        run(0, 0, 1, 5, 18'h0A5C3, '0, 0);
        run(0, 0, 3, 0, 18'h20000, '0, 0);
        check(last_res == -131072, "R6", "most negative code", last_res, -131072);
        run(0, 1, 2, 4, 18'h1FFFF, '0, 0);
        check(last_res == 131071, "R6", "most positive code", last_res, 131071);
        run(1, 0, 1, 10, 18'h3FFFF, 18'h12345, 0);
        run(1, 1, 4, 3, 18'h2AAAA, 18'h15555, 0);
        run(0, 0, 2, 6, 18'h00001, '0, 1);
        run(1, 0, 0, 1, 18'h00000, 18'h3FFFE, 1);
        check(last_res == -2, "R6", "chain second word sign", last_res, -2);
        check(overlap == 0, "R5", "strobe and clock high together", overlap, 0);
        done = 1;
        finish_up();
    end

endmodule